// File: doc/BRIEF.md
# Two-Set Masked Alarm Comparator

This block watches the live calendar fields of a time-of-day counter and raises an alarm when they agree with a programmed pattern. It holds two independent alarm sets. Each set has six compare registers: second, minute, hour, date, month and weekday. Every register carries its own enable bit in bit 7, above a 7-bit BCD compare value in bits 6:0. Only fields whose enable bit is 1 take part in the match. One mechanism therefore gives weekly, daily, hourly or one-shot alarms.

The comparison is evaluated only in cycles where the time-update strobe `tick` is high. When every enabled field of a set equals the live field, that set's flag is set. The flag stays set until software clears it. Software can poll the flags. The interrupt output is the OR, over both sets, of each flag gated by its interrupt enable.

The registers are reached through a simple address/data port. The write takes effect at the next clock edge. The read data is combinational.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, every compare register reads 00h (all fields disabled), both flags are 0 and `irq` is 0.
- R2: `addr[3]` selects the set. `addr[2:0]` selects the slot: 0 second, 1 minute, 2 hour, 3 date, 4 month, 6 weekday. A write with `wr_en` high stores `wdata` (bit 7 enable, bits 6:0 BCD value), and the stored byte reads back on `rdata`.
- R3: Slot 5 is a read-only year slot that always reads 20h, and writes to it are ignored. Slot 7 always reads 00h.
- R4: If `tick` is high and every enabled field of a set equals its live field, that set's flag is 1 from the next clock edge. If any enabled field differs, the flag is not set.
- R5: Fields whose enable bit is 0 do not affect the match. For example, enabling only hour and minute matches on any date, month, second or weekday.
- R6: A set whose six enable bits are all 0 never sets its flag.
- R7: The flag is never set in a cycle where `tick` is low, even if the fields match.
- R8: A set flag stays 1 until `flag_clr` for that set is high without a new match. It then reads 0 from the next edge.
- R9: If `flag_clr` for a set is high in the same cycle as a tick that matches, the flag is 1 after that edge.
- R10: `irq` is high exactly while some set has both its flag and its `irq_en` bit set. A flag is set whatever the value of `irq_en`.
- R11: The hour compare uses all 7 value bits, including the PM indicator in bit 5. So 08h (8 AM) does not match 28h (8 PM).
- R12: The two sets are independent. A write, match or clear on one set does not change the other set's registers or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-update strobe; the comparison is evaluated in this cycle |
| tm_sec | input | 7 | Live seconds, BCD |
| tm_min | input | 7 | Live minutes, BCD |
| tm_hour | input | 7 | Live hour, BCD (bit 5 is PM in 12-hour mode) |
| tm_date | input | 7 | Live day of month, BCD |
| tm_month | input | 7 | Live month, BCD |
| tm_wday | input | 7 | Live weekday, 0 to 6 |
| addr | input | 4 | Register address: set in bit 3, slot in bits 2:0 |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| flag_clr | input | 2 | Per-set flag clear |
| irq_en | input | 2 | Per-set interrupt enable |
| alarm_flag | output | 2 | Per-set sticky alarm flag |
| irq | output | 1 | Interrupt output, active high |

## Verification
The two functions that can fall in the same cycle are the software clear of a flag and a matching tick on the same set. The bench sets a daily alarm and leaves the live time on the matching value. It then raises `flag_clr` and `tick` together and expects the flag to be 1 after the edge. A following clear with no tick must drop the flag, which shows that the first clear was really applied and lost to the new match.

// File: rtl/alm_pkg.sv
package alm_pkg;
   localparam int FLD_N = 6;
   localparam logic [7:0] YEAR_RO = 8'h20;
   localparam logic [2:0] SLOT_YEAR = 3'd5;
   localparam logic [2:0] SLOT_WDAY = 3'd6;
   localparam logic [2:0] SLOT_SPARE = 3'd7;

   // slot -> storage index; weekday slot stored at index 5
   function automatic logic [2:0] slot_to_fld(input logic [2:0] slot);
      return (slot == SLOT_WDAY) ? 3'd5 : slot;
   endfunction

   function automatic logic slot_is_reg(input logic [2:0] slot);
      return (slot < SLOT_YEAR) || (slot == SLOT_WDAY);
   endfunction
endpackage

// File: rtl/alm_bank.sv
module alm_bank #(
   parameter int DATA_W = 8,
   parameter int FLD_N  = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_stb,
   input  logic [2:0]                     wr_fld,
   input  logic [DATA_W-1:0]              wdata,
   output logic [FLD_N-1:0][DATA_W-1:0]   cfg
);
   for (genvar f = 0; f < FLD_N; f++) begin : g_fld
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg[f] <= '0;
         else if (wr_stb && (wr_fld == 3'(f)))
            cfg[f] <= wdata;
      end
   end
endmodule

// File: rtl/alm_cmp.sv
module alm_cmp #(
   parameter int DATA_W = 8,
   parameter int VAL_W  = 7,
   parameter int FLD_N  = 6
) (
   input  logic [FLD_N-1:0][DATA_W-1:0] cfg,
   input  logic [FLD_N-1:0][VAL_W-1:0]  now,
   output logic                          hit
);
   logic [FLD_N-1:0] en;
   logic [FLD_N-1:0] ok;

   for (genvar f = 0; f < FLD_N; f++) begin : g_cmp
      assign en[f] = cfg[f][DATA_W-1];
      assign ok[f] = !en[f] || (cfg[f][VAL_W-1:0] == now[f]);
   end

   assign hit = (|en) && (&ok);
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_stb,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (set_stb)
         flag <= 1'b1;
      else if (clr)
         flag <= 1'b0;
   end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
   parameter int NUM_SETS = 2,
   parameter int DATA_W   = 8,
   parameter int VAL_W    = 7,
   localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
   localparam int ADDR_W  = SET_W + 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic [VAL_W-1:0]    tm_sec,
   input  logic [VAL_W-1:0]    tm_min,
   input  logic [VAL_W-1:0]    tm_hour,
   input  logic [VAL_W-1:0]    tm_date,
   input  logic [VAL_W-1:0]    tm_month,
   input  logic [VAL_W-1:0]    tm_wday,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   input  logic [NUM_SETS-1:0] flag_clr,
   input  logic [NUM_SETS-1:0] irq_en,
   output logic [NUM_SETS-1:0] alarm_flag,
   output logic                irq
);
   import alm_pkg::*;

   if (VAL_W + 1 != DATA_W) begin : g_bad_width
      $error("alarm_match_unit: DATA_W must be VAL_W+1");
   end
   if (NUM_SETS < 1 || NUM_SETS > 8) begin : g_bad_sets
      $error("alarm_match_unit: NUM_SETS out of range");
   end

   logic [2:0]                        slot;
   logic [SET_W-1:0]                  set_sel;
   logic [FLD_N-1:0][VAL_W-1:0]       now;
   logic [NUM_SETS-1:0][FLD_N-1:0][DATA_W-1:0] cfg;
   logic [NUM_SETS-1:0]               hit;

   assign slot    = addr[2:0];
   assign set_sel = addr[ADDR_W-1:3];

   assign now[0] = tm_sec;
   assign now[1] = tm_min;
   assign now[2] = tm_hour;
   assign now[3] = tm_date;
   assign now[4] = tm_month;
   assign now[5] = tm_wday;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic wr_here;
      assign wr_here = wr_en && (set_sel == SET_W'(s)) && slot_is_reg(slot);

      alm_bank #(.DATA_W(DATA_W), .FLD_N(FLD_N)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_stb (wr_here),
         .wr_fld (slot_to_fld(slot)),
         .wdata  (wdata),
         .cfg    (cfg[s])
      );

      alm_cmp #(.DATA_W(DATA_W), .VAL_W(VAL_W), .FLD_N(FLD_N)) u_cmp (
         .cfg (cfg[s]),
         .now (now),
         .hit (hit[s])
      );

      alm_flag u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_stb (tick && hit[s]),
         .clr     (flag_clr[s]),
         .flag    (alarm_flag[s])
      );
   end

   always_comb begin
      rdata = '0;
      if (slot == SLOT_YEAR)
         rdata = DATA_W'(YEAR_RO);
      else if (slot != SLOT_SPARE && int'(set_sel) < NUM_SETS)
         rdata = cfg[set_sel][slot_to_fld(slot)];
   end

   assign irq = |(alarm_flag & irq_en);
endmodule

// File: rtl/alm_chk.sv
module alm_chk #(
   parameter int NUM_SETS = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick,
   input logic [NUM_SETS-1:0] flag_clr,
   input logic [NUM_SETS-1:0] irq_en,
   input logic [NUM_SETS-1:0] alarm_flag,
   input logic                irq
);
   for (genvar s = 0; s < NUM_SETS; s++) begin : g_s
      AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(alarm_flag[s]) |-> $past(tick)); // R7
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (alarm_flag[s] && !flag_clr[s]) |=> alarm_flag[s]); // R8
      AST_CLR_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_clr[s] && !tick) |=> !alarm_flag[s]); // R8
   end

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((alarm_flag & irq_en) == '0) |-> !irq); // R10
   AST_IRQ_MASKED_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |-> !irq); // R10
endmodule

bind alarm_match_unit alm_chk #(.NUM_SETS(NUM_SETS)) u_alm_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .flag_clr   (flag_clr),
   .irq_en     (irq_en),
   .alarm_flag (alarm_flag),
   .irq        (irq)
);

// File: tb/alarm_match_unit_bench.sv
module alarm_match_unit_bench;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       tick = 0;
   logic [6:0] tm_sec = 0, tm_min = 0, tm_hour = 0, tm_date = 7'h01, tm_month = 7'h01, tm_wday = 0;
   logic [3:0] addr = 0;
   logic       wr_en = 0;
   logic [7:0] wdata = 0;
   logic [7:0] rdata;
   logic [1:0] flag_clr = 0, irq_en = 0, alarm_flag;
   logic       irq;
   int checks = 0, errors = 0;

   alarm_match_unit u_alarm_match_unit (.*);

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
      @(negedge clk); addr = a; #1;
      chk(req, rdata, exp);
   endtask

   task automatic set_time(input logic [6:0] s, mi, h, d, mo, w);
      @(negedge clk);
      tm_sec = s; tm_min = mi; tm_hour = h; tm_date = d; tm_month = mo; tm_wday = w;
   endtask

   task automatic pulse(input logic tk, input logic [1:0] clr);
      @(negedge clk); tick = tk; flag_clr = clr;
      @(negedge clk); tick = 0; flag_clr = 0;
   endtask

   task automatic t_reset;
      for (int a = 0; a < 16; a++)
         if (a[2:0] != 3'd5) rd_chk("R1 reg reset", 4'(a), 8'h00);
      chk("R1 flags", {6'b0, alarm_flag}, 8'h00);
      chk("R1 irq", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_regs;
      wr(4'h0, 8'h91); rd_chk("R2 sec", 4'h0, 8'h91);
      wr(4'h6, 8'h85); rd_chk("R2 wday", 4'h6, 8'h85);
      rd_chk("R12 set1 untouched", 4'hE, 8'h00);
      wr(4'h5, 8'hFF); rd_chk("R3 year", 4'h5, 8'h20);
      rd_chk("R3 year set1", 4'hD, 8'h20);
      wr(4'h7, 8'hAA); rd_chk("R3 spare", 4'h7, 8'h00);
      wr(4'h0, 8'h00); wr(4'h6, 8'h00);
   endtask

   task automatic t_weekly;
      wr(4'h6, 8'h83); wr(4'h2, 8'h88); wr(4'h1, 8'hB0);
      set_time(7'h12, 7'h30, 7'h08, 7'h15, 7'h06, 7'h3);
      pulse(0, 2'b00);
      chk("R7 no tick", {6'b0, alarm_flag}, 8'h00);
      set_time(7'h12, 7'h30, 7'h08, 7'h15, 7'h06, 7'h4);
      pulse(1, 2'b00);
      chk("R4 wday mismatch", {6'b0, alarm_flag}, 8'h00);
      set_time(7'h12, 7'h30, 7'h08, 7'h15, 7'h06, 7'h3);
      pulse(1, 2'b00);
      chk("R4 weekly hit / R6 set1 idle", {6'b0, alarm_flag}, 8'h01);
      #1 chk("R10 irq masked", {7'b0, irq}, 8'h00);
      @(negedge clk); irq_en = 2'b10; #1;
      chk("R10 other en", {7'b0, irq}, 8'h00);
      @(negedge clk); irq_en = 2'b01; #1;
      chk("R10 irq on", {7'b0, irq}, 8'h01);
      set_time(7'h00, 7'h00, 7'h00, 7'h01, 7'h01, 7'h0);
      pulse(1, 2'b00);
      chk("R8 sticky", {6'b0, alarm_flag}, 8'h01);
      pulse(0, 2'b01);
      chk("R8 cleared", {6'b0, alarm_flag}, 8'h00);
      #1 chk("R10 irq off", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_pm;
      set_time(7'h12, 7'h30, 7'h28, 7'h15, 7'h06, 7'h3);
      pulse(1, 2'b00);
      chk("R11 PM differs", {6'b0, alarm_flag}, 8'h00);
   endtask

   task automatic t_daily_race;
      wr(4'hA, 8'hA1); wr(4'h9, 8'h80);
      set_time(7'h45, 7'h00, 7'h21, 7'h29, 7'h02, 7'h5);
      pulse(1, 2'b00);
      chk("R5 daily / R12", {6'b0, alarm_flag}, 8'h02);
      pulse(1, 2'b10);
      chk("R9 clear loses to match", {6'b0, alarm_flag}, 8'h02);
      pulse(0, 2'b10);
      chk("R8 clear no tick", {6'b0, alarm_flag}, 8'h00);
      rd_chk("R12 set0 hour kept", 4'h2, 8'h88);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_regs();
      t_weekly();
      t_pm();
      t_daily_race();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule